// File: doc/BRIEF.md
# Watchdog Timer with Paired Clear

The block guards a processor core against runaway software. It divides the system clock by four to form a counting tick and counts those ticks toward a timeout of 2^n ticks. A static select input sets n to a value from 8 to 11. Software keeps the timer from expiring by issuing clear commands. Instruction decode lives elsewhere, so these commands reach the block as single-cycle strobes.

A static mode bit chooses between two ways of clearing the timer. In the first, a single clear command restarts the count. In the second, two different half-commands must both be seen, in either order, before the count restarts. A half that arrives alone is held until its partner arrives or until the count is restarted for another reason. The count also restarts on the active-low external reset and on entry to the halted power state.

When the count expires, the block sets a sticky time-out flag. What else happens depends on the power state:
- While running, it pulses a chip-reset request for one cycle.
- While halted, it pulses a wake-up request for one cycle instead. The core uses that request to reload only its program counter and stack pointer.

A static enable input turns the timer off completely. While the timer is off, every command is ignored and no request is ever produced.

Top module: `wdt_guard`

## Requirements
- R1: While `rst_n` is low, `chip_rst_req`, `wake_req` and `timeout_flag` are all 0. After `rst_n` is released, the count starts from zero.
- R2: When the block is enabled and no restart occurs, the count overflows after 4·2^(8+`tmo_sel`) system clocks. The first request pulse goes high in cycle 4·2^n after the restarted state, and later pulses follow at the same period. Each request lasts exactly one cycle.
- R3: An overflow while `halted` is 1 pulses `wake_req` and not `chip_rst_req`. An overflow while `halted` is 0 pulses `chip_rst_req` and not `wake_req`.
- R4: `timeout_flag` rises in the same cycle as the request pulse. It then stays at 1 until a restart by software, by halt entry or by reset.
- R5: With `dual_clr` = 0, a high `kick` restarts the count. In this mode `kick_a` and `kick_b` have no effect.
- R6: With `dual_clr` = 1, the count restarts only after both `kick_a` and `kick_b` have been seen. They may arrive in either order, with any gap, or in the same cycle. One half alone does not restart the count, and `kick` has no effect in this mode.
- R7: A pending half is discarded when the count restarts by halt entry, by overflow or by disable. A later lone partner half therefore does not restart the count.
- R8: A rising edge on `halted` restarts the count and clears `timeout_flag`.
- R9: With `wdt_en` = 0, no request pulse occurs and all strobes are ignored. `timeout_flag` holds its value, and the count is held at zero, so the count restarts from zero when the timer is enabled again.
- R10: A software restart in the same cycle as an overflow wins: no request pulse is produced and the count restarts.
- R11: A completed software restart clears `timeout_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External reset, active low, asynchronous |
| wdt_en | input | 1 | Static enable; 0 makes the timer inert |
| tmo_sel | input | 2 | Static timeout select, n = 8 + tmo_sel |
| dual_clr | input | 1 | Static clear mode: 0 single command, 1 paired commands |
| kick | input | 1 | Single clear strobe |
| kick_a | input | 1 | First half of the paired clear |
| kick_b | input | 1 | Second half of the paired clear |
| halted | input | 1 | Power state level, 1 while halted |
| chip_rst_req | output | 1 | One-cycle chip reset request |
| wake_req | output | 1 | One-cycle wake-up request |
| timeout_flag | output | 1 | Sticky time-out indication |

## Verification
The hardest case to reach is a half-command that is still pending when another kind of restart discards it. Reaching it takes a lone `kick_a`, then a halt entry, and then only a `kick_b` for the rest of the window. The bench applies exactly that sequence and waits for the overflow that must still follow. A second precise case is a clear strobe landing on the exact overflow tick. The bench places it by counting 4·2^n cycles from a known restart. A behavioural reference based on elapsed cycles checks all outputs on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned WDT_PRE_W = 2;
    localparam int unsigned WDT_N_MIN = 8;
    localparam int unsigned WDT_SEL_W = 2;
    localparam int unsigned WDT_CNT_W = WDT_N_MIN + (1 << WDT_SEL_W) - 1;

    typedef struct packed {
        logic halt_q;
        logic flag_q;
        logic rst_q;
        logic wake_q;
    } wdt_top_state_t;
endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int unsigned PRE_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hold,
    output logic tick
);
    typedef struct packed {
        logic [PRE_W-1:0] pre;
    } pre_state_t;

    pre_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (hold) s_d.pre = '0;
        else      s_d.pre = s_q.pre + 1'b1;
        tick = &s_q.pre;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_clear_ctl.sv
module wdt_clear_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic dual,
    input  logic kick,
    input  logic kick_a,
    input  logic kick_b,
    input  logic flush,
    output logic sw_clr
);
    typedef struct packed {
        logic pend_a;
        logic pend_b;
    } clr_state_t;

    clr_state_t s_d, s_q;
    logic have_a, have_b;

    always_comb begin
        s_d    = s_q;
        have_a = s_q.pend_a | kick_a;
        have_b = s_q.pend_b | kick_b;
        if (!enable)   sw_clr = 1'b0;
        else if (dual) sw_clr = have_a & have_b;
        else           sw_clr = kick;
        if (!enable || sw_clr || flush) begin
            s_d = '0;
        end else if (dual) begin
            s_d.pend_a = have_a;
            s_d.pend_b = have_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int unsigned N_MIN = 8,
    parameter int unsigned SEL_W = 2,
    parameter int unsigned CNT_W = N_MIN + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             tick,
    input  logic [SEL_W-1:0] sel,
    output logic             ovf
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t       s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             at_end;
    int unsigned      width_n;

    always_comb begin
        s_d     = s_q;
        width_n = N_MIN + 32'(sel);
        limit   = {CNT_W{1'b1}} >> (CNT_W - width_n);
        at_end  = (s_q.cnt == limit);
        ovf     = tick & at_end & ~restart;
        if (restart)     s_d.cnt = '0;
        else if (tick)   s_d.cnt = at_end ? '0 : s_q.cnt + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_pkg::*;
#(
    parameter int unsigned PRE_W = WDT_PRE_W,
    parameter int unsigned N_MIN = WDT_N_MIN,
    parameter int unsigned SEL_W = WDT_SEL_W,
    localparam int unsigned CNT_W = N_MIN + (1 << SEL_W) - 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wdt_en,
    input  logic [SEL_W-1:0] tmo_sel,
    input  logic             dual_clr,
    input  logic             kick,
    input  logic             kick_a,
    input  logic             kick_b,
    input  logic             halted,
    output logic             chip_rst_req,
    output logic             wake_req,
    output logic             timeout_flag
);
    wdt_top_state_t s_d, s_q;
    logic halt_rise, sw_clr, restart, tick, ovf;

    assign halt_rise = wdt_en & halted & ~s_q.halt_q;
    assign restart   = ~wdt_en | sw_clr | halt_rise;

    wdt_prescale #(.PRE_W(PRE_W)) u_pre (
        .clk   (clk),
        .rst_n (rst_n),
        .hold  (restart),
        .tick  (tick)
    );

    wdt_clear_ctl u_clr (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (wdt_en),
        .dual   (dual_clr),
        .kick   (kick),
        .kick_a (kick_a),
        .kick_b (kick_b),
        .flush  (halt_rise | ovf),
        .sw_clr (sw_clr)
    );

    wdt_count #(.N_MIN(N_MIN), .SEL_W(SEL_W), .CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (restart),
        .tick    (tick),
        .sel     (tmo_sel),
        .ovf     (ovf)
    );

    always_comb begin
        s_d        = s_q;
        s_d.halt_q = halted;
        s_d.rst_q  = ovf & ~halted;
        s_d.wake_q = ovf & halted;
        if (sw_clr || halt_rise) s_d.flag_q = 1'b0;
        else if (ovf)            s_d.flag_q = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign chip_rst_req = s_q.rst_q;
    assign wake_req     = s_q.wake_q;
    assign timeout_flag = s_q.flag_q;
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic wdt_en,
    input logic dual_clr,
    input logic kick,
    input logic kick_a,
    input logic kick_b,
    input logic halted,
    input logic chip_rst_req,
    input logic wake_req,
    input logic timeout_flag
);
    assert_one_request_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(chip_rst_req && wake_req));

    assert_pulse_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst_req || wake_req) |=> !(chip_rst_req || wake_req));

    assert_flag_with_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (chip_rst_req || wake_req) |-> timeout_flag);

    assert_off_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wdt_en |=> !(chip_rst_req || wake_req));

    assert_single_kick_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en && !dual_clr && kick) |=> !(chip_rst_req || wake_req) && !timeout_flag);

    assert_pair_kick_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en && dual_clr && kick_a && kick_b) |=> !(chip_rst_req || wake_req) && !timeout_flag);

    assert_halt_entry_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wdt_en && $rose(halted)) |=> !timeout_flag);

    assert_wake_halted_R3: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> $past(halted));
endmodule

bind wdt_guard wdt_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wdt_en       (wdt_en),
    .dual_clr     (dual_clr),
    .kick         (kick),
    .kick_a       (kick_a),
    .kick_b       (kick_b),
    .halted       (halted),
    .chip_rst_req (chip_rst_req),
    .wake_req     (wake_req),
    .timeout_flag (timeout_flag)
);

// File: tb/tb_wdt_guard.sv
`timescale 1ns/1ps
module tb_wdt_guard;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wdt_en = 1'b1;
    logic [1:0] tmo_sel = 2'd0;
    logic       dual_clr = 1'b0;
    logic       kick = 1'b0, kick_a = 1'b0, kick_b = 1'b0;
    logic       halted = 1'b0;
    logic       chip_rst_req, wake_req, timeout_flag;

    int checks = 0;
    int fails  = 0;
    int n_rst  = 0;
    int n_wake = 0;
    int cyc    = 0;
    string tag = "R1";
    bit done   = 0;

    // reference model state
    int age = 0;
    bit pa = 0, pb = 0, m_flag = 0, m_hq = 0, m_rst = 0, m_wake = 0;

    always #5 clk = ~clk;

    wdt_guard dut (
        .clk(clk), .rst_n(rst_n), .wdt_en(wdt_en), .tmo_sel(tmo_sel),
        .dual_clr(dual_clr), .kick(kick), .kick_a(kick_a), .kick_b(kick_b),
        .halted(halted), .chip_rst_req(chip_rst_req), .wake_req(wake_req),
        .timeout_flag(timeout_flag)
    );

    // behavioural reference: elapsed cycles since last restart
    always @(posedge clk) begin
        bit rise, swc, ha, hb;
        if (!rst_n) begin
            age = 0; pa = 0; pb = 0; m_flag = 0; m_hq = 0; m_rst = 0; m_wake = 0;
        end else begin
            m_rst = 0; m_wake = 0;
            rise = halted && !m_hq;
            m_hq = halted;
            if (!wdt_en) begin
                age = 0; pa = 0; pb = 0;
            end else begin
                ha = pa || kick_a; hb = pb || kick_b;
                swc = dual_clr ? (ha && hb) : kick;
                if (dual_clr) begin pa = ha; pb = hb; end
                if (swc || rise) begin
                    age = 0; pa = 0; pb = 0; m_flag = 0;
                end else if (age + 1 == (4 << (8 + tmo_sel))) begin
                    age = 0; pa = 0; pb = 0; m_flag = 1;
                    if (halted) m_wake = 1; else m_rst = 1;
                end else begin
                    age = age + 1;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done) begin
            cyc++;
            checks++;
            if (chip_rst_req !== m_rst || wake_req !== m_wake || timeout_flag !== m_flag) begin
                fails++;
                $display("FAIL %s cycle %0d: rst/wake/flag actual %b%b%b expected %b%b%b",
                         tag, cyc, chip_rst_req, wake_req, timeout_flag, m_rst, m_wake, m_flag);
            end
            if (chip_rst_req === 1'b1) n_rst++;
            if (wake_req === 1'b1) n_wake++;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(input bit s, input bit a, input bit b);
        @(negedge clk);
        kick = s; kick_a = a; kick_b = b;
        @(negedge clk);
        kick = 0; kick_a = 0; kick_b = 0;
    endtask

    task automatic check_eq(input string t, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", t, got, exp);
        end
    endtask

    task automatic zero_counts();
        n_rst = 0; n_wake = 0;
    endtask

    task automatic reconfig(input bit en, input bit dual, input logic [1:0] sel);
        @(negedge clk);
        wdt_en = 0;
        wait_cyc(2);
        dual_clr = dual; tmo_sel = sel; wdt_en = en;
    endtask

    initial begin
        wait_cyc(4);
        tag = "R1";
        check_eq("R1 reset rst_req", int'(chip_rst_req), 0);
        check_eq("R1 reset wake_req", int'(wake_req), 0);
        check_eq("R1 reset flag", int'(timeout_flag), 0);
        rst_n = 1;

        tag = "R2"; zero_counts();
        wait_cyc(1030);
        check_eq("R2 first timeout n=8", n_rst, 1);
        check_eq("R4 flag after timeout", int'(timeout_flag), 1);

        tag = "R11";
        strobe(1, 0, 0); wait_cyc(1);
        check_eq("R11 flag cleared by kick", int'(timeout_flag), 0);

        tag = "R5"; zero_counts();
        for (int i = 0; i < 5; i++) begin strobe(1, 0, 0); wait_cyc(600); end
        check_eq("R5 kicks hold off timeout", n_rst, 0);
        zero_counts();
        for (int i = 0; i < 4; i++) begin strobe(0, 1, 1); wait_cyc(600); end
        check_eq("R5 halves ignored in single mode", int'(n_rst > 0), 1);

        reconfig(1, 1, 2'd0);
        tag = "R6"; zero_counts();
        for (int i = 0; i < 5; i++) begin
            strobe(0, 1, 0); wait_cyc(300); strobe(0, 0, 1); wait_cyc(300);
        end
        for (int i = 0; i < 5; i++) begin
            strobe(0, 0, 1); wait_cyc(300); strobe(0, 1, 0); wait_cyc(300);
        end
        for (int i = 0; i < 5; i++) begin strobe(0, 1, 1); wait_cyc(600); end
        check_eq("R6 pairs hold off timeout", n_rst, 0);
        zero_counts();
        for (int i = 0; i < 8; i++) begin strobe(1, 1, 0); wait_cyc(300); end
        check_eq("R6 lone half and kick do not clear", int'(n_rst > 0), 1);

        tag = "R7";
        strobe(0, 1, 1); wait_cyc(5);
        strobe(0, 1, 0); wait_cyc(10);
        @(negedge clk); halted = 1;
        @(negedge clk); halted = 0;
        wait_cyc(2);
        check_eq("R8 halt entry clears flag", int'(timeout_flag), 0);
        zero_counts();
        wait_cyc(500);
        strobe(0, 0, 1);
        wait_cyc(620);
        check_eq("R7 pending half dropped by halt entry", n_rst, 1);

        tag = "R3";
        strobe(0, 1, 1);
        zero_counts();
        @(negedge clk); halted = 1;
        wait_cyc(2100);
        check_eq("R3 wake pulses while halted", n_wake, 2);
        check_eq("R3 no reset while halted", n_rst, 0);
        @(negedge clk); halted = 0;

        reconfig(1, 0, 2'd0);
        tag = "R10"; zero_counts();
        strobe(1, 0, 0);
        wait_cyc(1023);
        kick = 1;
        @(negedge clk); kick = 0;
        wait_cyc(1000);
        check_eq("R10 kick on overflow tick wins", n_rst, 0);

        tag = "R9";
        wait_cyc(200);
        @(negedge clk); wdt_en = 0;
        zero_counts();
        for (int i = 0; i < 6; i++) begin strobe(1, 1, 1); wait_cyc(800); end
        check_eq("R9 disabled gives no request", n_rst + n_wake, 0);
        @(negedge clk); wdt_en = 1;
        wait_cyc(1030);
        check_eq("R9 restart from zero after enable", n_rst, 1);

        tag = "R2";
        for (int s = 1; s < 4; s++) begin
            reconfig(1, 0, 2'(s));
            zero_counts();
            wait_cyc((4 << (8 + s)) + 5);
            check_eq("R2 timeout length per select", n_rst, 1);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait_cyc(150000);
        if (!done) begin
            done = 1;
            fails++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule